// File: doc/BRIEF.md
# Polyphase FIR Interpolator with Ready Pacing

This block raises the sample rate of a signed stream by an integer factor L. For every input sample it accepts, it produces L filtered output samples, one per clock. The FIR of TAPS coefficients is split into L sub-filters of TAPS/L taps each. Output slot p of an interpolation cycle is computed by sub-filter p. That sub-filter weights the most recent TAPS/L input samples with every L-th coefficient, starting at coefficient p.

The coefficients live outside the block. The block drives the index of the phase it is computing, and the surrounding logic returns that phase's row of coefficients in the same cycle. The input side uses a valid/ready pair. After each accepted sample, ready is held low while the block emits the interpolated outputs. A source that keeps valid asserted is therefore paced to one sample every L clocks. A slower source simply finds ready waiting for it.

Top module: `interp_poly`

## Requirements
- R1: Each accepted sample (in_valid and ready both high at a rising edge) produces exactly L cycles with out_valid high, in consecutive cycles; out_valid is low otherwise.
- R2: The output of phase p (p = 0 .. L-1) equals the low OW bits of (sum over j = 0 .. K-1 of h[p + j*L] * x[j]) arithmetically shifted right by SHIFT, where K = TAPS/L, x[0] is the newest accepted sample, x[j] the one accepted j samples earlier, and the sum is formed at full precision in two's complement.
- R3: Ready goes low in the cycle after an acceptance, stays low for exactly L-1 cycles, and is high again in the L-th cycle after the acceptance.
- R4: A sample presented while ready is low is not taken into the delay line and causes no output.
- R5: With in_valid held high, a new sample is accepted every L cycles, ready is high one cycle in L, and out_valid stays high without gaps.
- R6: While no valid sample arrives, ready stays high and no output is produced, for any idle length.
- R7: With PIPE = 0, phase 0 of an accepted sample appears on out_data two rising edges after the acceptance edge, and phase k appears k cycles later. PIPE = 1 adds one cycle.
- R8: In the cycle after an acceptance, coef_phase is 0, and it advances by one each cycle up to L-1. coef_row must hold h[coef_phase + j*L] as a signed CW-bit value in bits [j*CW +: CW] during the same cycle.
- R9: A synchronous reset, rst high at a rising edge, zeroes the delay line, clears the phase sequencing and out_valid, and leaves ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is valid |
| in_data | input | DW | Signed input sample |
| ready | output | 1 | Block can take a sample this cycle |
| coef_phase | output | PW | Phase whose coefficient row is needed |
| coef_row | input | K*CW | Coefficients of that phase, tap j in bits [j*CW +: CW] |
| out_valid | output | 1 | Output sample is valid |
| out_data | output | OW | Filtered, shifted and truncated output sample |

## Verification
The bench checks ready against the exact L-1 busy window and keeps in_valid high with changing junk data during that window. A design that opened ready one cycle early or late would break the one-in-L acceptance spacing. A design that sampled data while busy would corrupt the delay line, and every later output would miss its scoreboard value. An impulse exposes each coefficient in its phase slot, so a wrong stride or tap order appears as a swapped value. Full-scale positive and negative samples drive the sum beyond the product width, which catches a narrow accumulator or a logical shift. A reset in the middle of traffic followed by an impulse shows whether stale samples survive in the delay line.

// File: rtl/interp_pkg.sv
package interp_pkg;
   // Index width that never collapses to zero bits.
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/interp_pace.sv
module interp_pace #(
   parameter int L  = 3,
   parameter int PW = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   output logic          ready,
   output logic          accept,
   output logic [PW-1:0] phase,
   output logic          active
);
   logic [PW-1:0] phase_q;
   logic          active_q;

   assign accept = in_valid & ready;

   generate
      if (L == 1) begin : g_no_busy
         assign ready = 1'b1;
      end else begin : g_busy
         logic [PW-1:0] busy_q;
         always_ff @(posedge clk) begin
            if (rst)                 busy_q <= '0;
            else if (accept)         busy_q <= PW'(L - 1);
            else if (busy_q != '0)   busy_q <= busy_q - PW'(1);
         end
         assign ready = (busy_q == '0);
      end
   endgenerate

   // Phase sequencing: a new acceptance always restarts at phase 0.
   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q  <= '0;
         active_q <= 1'b0;
      end else if (accept) begin
         phase_q  <= '0;
         active_q <= 1'b1;
      end else if (active_q) begin
         if (phase_q == PW'(L - 1)) active_q <= 1'b0;
         else                       phase_q  <= phase_q + PW'(1);
      end
   end

   assign phase  = phase_q;
   assign active = active_q;
endmodule

// File: rtl/interp_taps.sv
module interp_taps #(
   parameter int DW = 16,
   parameter int K  = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            accept,
   input  logic [DW-1:0]   din,
   output logic [K*DW-1:0] taps
);
   logic [DW-1:0] line_q [K];

   generate
      for (genvar j = 0; j < K; j++) begin : g_stage
         if (j == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (rst)         line_q[j] <= '0;
               else if (accept) line_q[j] <= din;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (rst)         line_q[j] <= '0;
               else if (accept) line_q[j] <= line_q[j-1];
            end
         end
         assign taps[j*DW +: DW] = line_q[j];
      end
   endgenerate
endmodule

// File: rtl/interp_mac.sv
module interp_mac import interp_pkg::*; #(
   parameter int DW    = 16,
   parameter int CW    = 16,
   parameter int K     = 4,
   parameter int OW    = 24,
   parameter int SHIFT = 4,
   parameter int PIPE  = 0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            en,
   input  logic [K*DW-1:0] taps,
   input  logic [K*CW-1:0] coefs,
   output logic            out_valid,
   output logic [OW-1:0]   out_data
);
   localparam int PRW = DW + CW;
   localparam int AW  = PRW + cnt_width(K);

   logic signed [PRW-1:0] prod_c [K];
   logic signed [PRW-1:0] prod_s [K];
   logic                  vld_s;
   logic signed [AW-1:0]  acc_c;

   generate
      for (genvar j = 0; j < K; j++) begin : g_mul
         assign prod_c[j] = $signed(taps[j*DW +: DW]) * $signed(coefs[j*CW +: CW]);
      end

      if (PIPE != 0) begin : g_pipe
         always_ff @(posedge clk) begin
            if (rst) vld_s <= 1'b0;
            else     vld_s <= en;
         end
         for (genvar j = 0; j < K; j++) begin : g_preg
            always_ff @(posedge clk) prod_s[j] <= prod_c[j];
         end
      end else begin : g_flat
         assign vld_s = en;
         for (genvar j = 0; j < K; j++) begin : g_pass
            assign prod_s[j] = prod_c[j];
         end
      end
   endgenerate

   always_comb begin
      acc_c = '0;
      for (int j = 0; j < K; j++) acc_c = acc_c + AW'(prod_s[j]);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= vld_s;
         if (vld_s) out_data <= OW'(acc_c >>> SHIFT);
      end
   end
endmodule

// File: rtl/interp_poly.sv
module interp_poly import interp_pkg::*; #(
   parameter int DW    = 16,
   parameter int CW    = 16,
   parameter int L     = 3,
   parameter int TAPS  = 12,
   parameter int OW    = 24,
   parameter int SHIFT = 4,
   parameter int PIPE  = 0,
   localparam int K    = TAPS / L,
   localparam int PW   = cnt_width(L)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   input  logic [DW-1:0]   in_data,
   output logic            ready,
   output logic [PW-1:0]   coef_phase,
   input  logic [K*CW-1:0] coef_row,
   output logic            out_valid,
   output logic [OW-1:0]   out_data
);
   initial begin : g_param_check
      assert (L >= 1 && TAPS >= L && (TAPS % L) == 0)
         else $fatal(1, "TAPS must be a positive multiple of L");
      assert (OW <= DW + CW + cnt_width(K))
         else $fatal(1, "OW wider than the accumulator");
      assert (PIPE == 0 || PIPE == 1)
         else $fatal(1, "PIPE must be 0 or 1");
   end

   logic            accept;
   logic            active;
   logic [K*DW-1:0] taps;

   interp_pace #(.L(L), .PW(PW)) u_pace (
      .clk(clk), .rst(rst), .in_valid(in_valid), .ready(ready),
      .accept(accept), .phase(coef_phase), .active(active)
   );

   interp_taps #(.DW(DW), .K(K)) u_taps (
      .clk(clk), .rst(rst), .accept(accept), .din(in_data), .taps(taps)
   );

   interp_mac #(.DW(DW), .CW(CW), .K(K), .OW(OW), .SHIFT(SHIFT), .PIPE(PIPE)) u_mac (
      .clk(clk), .rst(rst), .en(active), .taps(taps), .coefs(coef_row),
      .out_valid(out_valid), .out_data(out_data)
   );
endmodule

// File: rtl/interp_poly_chk.sv
module interp_poly_chk #(
   parameter int L    = 3,
   parameter int PW   = 2,
   parameter int PIPE = 0
) (
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic          ready,
   input logic [PW-1:0] coef_phase,
   input logic          out_valid
);
   localparam int SW = $clog2(L + 1);

   logic          acc_ev;
   logic [SW-1:0] since_q;
   logic          rst_q;

   assign acc_ev = in_valid && ready;

   // Cycles since the last acceptance, saturating at L.
   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst)                    since_q <= SW'(L);
      else if (acc_ev)            since_q <= SW'(1);
      else if (since_q < SW'(L))  since_q <= since_q + SW'(1);
   end

   // R3, R5, R6: ready is low exactly in the L-1 cycles after an acceptance.
   p_ready_window_r3: assert property (@(posedge clk) disable iff (rst)
      (since_q < SW'(L)) == !ready);

   // R8: phase restarts at zero after every acceptance.
   p_phase_start_r8: assert property (@(posedge clk) disable iff (rst)
      acc_ev |=> coef_phase == '0);

   // R8: phase steps by one while the block is busy.
   p_phase_step_r8: assert property (@(posedge clk) disable iff (rst)
      !ready |=> coef_phase == $past(coef_phase) + PW'(1));

   // R7: the first output follows the acceptance at a fixed latency.
   generate
      if (PIPE != 0) begin : g_lat3
         p_first_out_r7: assert property (@(posedge clk) disable iff (rst)
            acc_ev |-> ##3 out_valid);
      end else begin : g_lat2
         p_first_out_r7: assert property (@(posedge clk) disable iff (rst)
            acc_ev |-> ##2 out_valid);
      end
   endgenerate

   // R9: directly after a reset edge, ready is high and no output is flagged.
   always @(posedge clk) begin
      if (rst_q) begin
         p_reset_state_r9: assert (ready && !out_valid);
      end
   end
endmodule

bind interp_poly interp_poly_chk #(.L(L), .PW(PW), .PIPE(PIPE)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .ready(ready),
   .coef_phase(coef_phase), .out_valid(out_valid)
);

// File: tb/interp_poly_tb.sv
`timescale 1ns/1ps
module interp_poly_tb;
   import interp_pkg::*;

   localparam int DW = 16, CW = 16, L = 3, TAPS = 12, OW = 24, SHIFT = 4, PIPE = 0;
   localparam int K  = TAPS / L;
   localparam int PW = cnt_width(L);

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            in_valid = 1'b0;
   logic [DW-1:0]   in_data = '0;
   logic            ready;
   logic [PW-1:0]   coef_phase;
   logic [K*CW-1:0] coef_row;
   logic            out_valid;
   logic [OW-1:0]   out_data;

   interp_poly #(.DW(DW), .CW(CW), .L(L), .TAPS(TAPS), .OW(OW), .SHIFT(SHIFT), .PIPE(PIPE)) u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .ready(ready),
      .coef_phase(coef_phase), .coef_row(coef_row), .out_valid(out_valid), .out_data(out_data)
   );

   always #10 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_fail = 0;

   function automatic int hc(input int i);
      logic [15:0] v;
      v = 16'(i * 20011 + 12345);
      return int'($signed(v));
   endfunction

   // Coefficient bank outside the block, laid out as R8 states.
   always_comb begin
      for (int j = 0; j < K; j++)
         coef_row[j*CW +: CW] = CW'(hc(int'(coef_phase) + j * L));
   end

   typedef struct {
      logic [OW-1:0] val;
      int            due;
      int            ph;
   } exp_t;
   exp_t q[$];
   int   hist[K];

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic logic [OW-1:0] model_out(input int p);
      longint acc = 0;
      for (int j = 0; j < K; j++) acc += longint'(hc(p + j * L)) * longint'(hist[j]);
      return OW'(acc >>> SHIFT);
   endfunction

   // Monitor: compare each flagged output with the head of the scoreboard.
   always @(negedge clk) begin
      if (!rst) begin
         if (out_valid) begin
            if (q.size() == 0) begin
               chk(1'b0, "R1", "output with nothing expected", longint'(out_data), 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(out_data == e.val, "R2", $sformatf("phase %0d value", e.ph),
                   longint'($signed(out_data)), longint'($signed(e.val)));
               chk(cyc == e.due, "R7", "output cycle", cyc, e.due);
            end
         end else if (q.size() != 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            chk(1'b0, "R1", $sformatf("missing output of phase %0d", e.ph), cyc, e.due);
         end
      end
   end

   int last_acc  = -1;
   bit prev_gap0 = 1'b0;

   // Driver: called at a negedge, returns at a negedge.
   task automatic feed(input logic signed [DW-1:0] d, input int gap, input bit junk);
      int a;
      in_valid = 1'b1;
      in_data  = d;
      while (!ready) @(negedge clk);
      a = cyc + 1;
      if (prev_gap0) chk(a - last_acc == L, "R5", "acceptance spacing", a - last_acc, L);
      last_acc = a;
      for (int j = K - 1; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = int'(d);
      for (int k = 0; k < L; k++) begin
         exp_t e;
         e.val = model_out(k);
         e.due = a + 1 + k + PIPE;
         e.ph  = k;
         q.push_back(e);
      end
      @(negedge clk);
      for (int i = 1; i < L; i++) begin
         chk(ready == 1'b0, "R3", "ready in busy window", ready, 0);
         if (junk) begin
            in_valid = 1'b1;           // R4: ignored while busy
            in_data  = ~d ^ DW'(16'h5a5a + i);
         end else begin
            in_valid = 1'b0;
         end
         @(negedge clk);
      end
      chk(ready == 1'b1, "R3", "ready after busy window", ready, 1);
      if (gap > 0) begin
         in_valid = 1'b0;
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            chk(ready == 1'b1, "R6", "ready while idle", ready, 1);
         end
      end
      prev_gap0 = (gap == 0);
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "R1", "watchdog expired", cyc, 0);
      finish_run();
   end

   initial begin
      for (int j = 0; j < K; j++) hist[j] = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk(ready == 1'b1, "R9", "ready after reset", ready, 1);
      chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);

      // R6: idle source, no outputs expected
      repeat (6) @(negedge clk);
      chk(ready == 1'b1, "R6", "ready after idle", ready, 1);

      // R2: impulse walks through every coefficient
      feed(16'sd1000, 2, 1'b0);
      for (int i = 0; i < K; i++) feed(16'sd0, 0, 1'b0);

      // R4, R5: valid held high, junk data during busy cycles
      for (int i = 0; i < 8; i++) feed(DW'(i * 300 - 1000), 0, 1'b1);

      // R2: full-scale values stress accumulator width and sign
      feed(16'sh7fff, 0, 1'b1);
      feed(16'sh8000, 0, 1'b1);
      feed(16'sh8000, 0, 1'b1);
      feed(16'sh7fff, 1, 1'b1);
      feed(16'sh8000, 0, 1'b0);

      // R6: slow source with long idle gaps
      feed(16'sd123, 7, 1'b0);
      feed(-16'sd4567, 11, 1'b1);
      drain();

      // R9: reset in the middle of use must clear the delay line
      feed(16'sd2222, 0, 1'b0);
      feed(-16'sd3333, 0, 1'b0);
      drain();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      for (int j = 0; j < K; j++) hist[j] = 0;
      prev_gap0 = 1'b0;
      chk(ready == 1'b1, "R9", "ready after second reset", ready, 1);
      chk(out_valid == 1'b0, "R9", "out_valid after second reset", out_valid, 0);
      feed(16'sd100, 0, 1'b0);
      feed(16'sd0, 2, 1'b0);
      drain();
      chk(q.size() == 0, "R1", "scoreboard empty at end", q.size(), 0);
      finish_run();
   end
endmodule